// File: doc/BRIEF.md
# Supply Supervisor Reset Timer

This block turns two supply-status flags into a clean system reset. One flag reports that the supply sits above the trip threshold. The other reports that the supply is high enough for the output to mean anything at all. Reset is held asserted while the supply is below the threshold. It is released only after the supply has stayed above the threshold, without a break, for a hold time counted in system clock cycles. The default hold is 25,000,000 cycles, which is about 200 ms at 125 MHz.

The trip flag is asynchronous to the clock, so it passes through a two-flop synchronizer before any logic uses it. Any drop of the synced flag clears the hold counter. A brownout therefore always costs a full new hold period. While the minimum-valid flag is low, it acts as an asynchronous clear for all state and drives the output to its asserted level at once. The polarity of the output is chosen by a parameter. The block has no streaming data path, so every pin is a plain level.

Top module: `supply_rst_timer`

## Requirements
- R1: Before the minimum-valid flag has ever gone high, the output sits at its asserted level.
- R2: When the trip flag falls, the output is asserted after the second rising clock edge that samples it low, and it stays asserted while the flag stays low.
- R3: When the trip flag rises and stays high, the output is released after exactly HOLD_CYCLES+2 rising edges. The first of these edges is the first one that samples the flag high.
- R4: A low sample of the trip flag during the hold count, even for a single cycle, clears the count to zero. Release then needs a full new run of high samples.
- R5: Once released, the output stays released for as long as the trip flag stays high. The hold counter saturates at HOLD_CYCLES and never wraps.
- R6: While the minimum-valid flag is low, the output is asserted without waiting for a clock edge, and all counter and synchronizer state is cleared. After the flag returns high, a full R3 sequence is needed before release.
- R7: With ACTIVE_LOW=1 the asserted level is 0. With ACTIVE_LOW=0 the asserted level is 1.
- R8: The trip flag goes through two flops in series before it is used. The second flop always holds the value the first flop held one cycle earlier.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| vmin_ok | input | 1 | Supply above minimum-valid level; low clears the block asynchronously |
| vtrip_ok | input | 1 | Supply above trip threshold, asynchronous |
| rst_out | output | 1 | Reset output, polarity set by ACTIVE_LOW |

## Verification
A hold counter left uncleared after a dip shows up at the port as a reset release that comes early. It appears on the first edge where the stale count reaches the limit, well before the HOLD_CYCLES+2 edges that a clean run needs. A wrong synchronizer depth moves both the assert edge and the release edge by one cycle, and the output is compared on every cycle. A polarity or saturation fault shows at the output on the very first edge that passes through the affected state.

// File: rtl/supply_rst_pkg.sv
package supply_rst_pkg;
  function automatic int cnt_width(input longint unsigned limit);
    int w;
    w = 1;
    while ((64'd1 << w) <= limit) w++;
    return w;
  endfunction
endpackage

// File: rtl/supply_rst_sync.sv
module supply_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic clr_n,
  input  logic d_async,
  output logic q_sync
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk or negedge clr_n) begin
    if (!clr_n) chain <= '0;
    else        chain <= {chain[STAGES-2:0], d_async};
  end

  assign q_sync = chain[STAGES-1];

  // R8: the final stage follows the one before it, one cycle later
  a_r8_two_stage: assert property (@(posedge clk) disable iff (!clr_n)
    chain[STAGES-1] == $past(chain[STAGES-2]));
endmodule

// File: rtl/supply_rst_hold.sv
module supply_rst_hold #(
  parameter longint unsigned HOLD_CYCLES = 64'd25000000,
  localparam int CW = supply_rst_pkg::cnt_width(HOLD_CYCLES)
) (
  input  logic clk,
  input  logic clr_n,
  input  logic above,
  output logic done
);
  localparam logic [CW-1:0] LIMIT = CW'(HOLD_CYCLES);
  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge clr_n) begin
    if (!clr_n)          cnt <= '0;
    else if (!above)     cnt <= '0;
    else if (cnt != LIMIT) cnt <= cnt + 1'b1;
  end

  assign done = (cnt == LIMIT);

  // R4: a low sample clears the count
  a_r4_dip_clears: assert property (@(posedge clk) disable iff (!clr_n)
    !above |=> cnt == '0);
  // R5: the count never goes past the limit
  a_r5_saturate: assert property (@(posedge clk) disable iff (!clr_n)
    cnt <= LIMIT);
  // R5: once at the limit with the flag high, it stays there
  a_r5_hold_limit: assert property (@(posedge clk) disable iff (!clr_n)
    (done && above) |=> done);
endmodule

// File: rtl/supply_rst_drive.sv
module supply_rst_drive #(
  parameter bit ACTIVE_LOW = 1'b1
) (
  input  logic asserted,
  output logic pin
);
  generate
    if (ACTIVE_LOW) begin : g_low
      assign pin = ~asserted;
    end else begin : g_high
      assign pin = asserted;
    end
  endgenerate
endmodule

// File: rtl/supply_rst_timer.sv
module supply_rst_timer #(
  parameter longint unsigned HOLD_CYCLES = 64'd25000000,
  parameter bit ACTIVE_LOW = 1'b1
) (
  input  logic clk,
  input  logic vmin_ok,
  input  logic vtrip_ok,
  output logic rst_out
);
  logic above_s;
  logic hold_done;
  logic rst_act;

  supply_rst_sync #(.STAGES(2)) u_sync (
    .clk(clk), .clr_n(vmin_ok), .d_async(vtrip_ok), .q_sync(above_s)
  );

  supply_rst_hold #(.HOLD_CYCLES(HOLD_CYCLES)) u_hold (
    .clk(clk), .clr_n(vmin_ok), .above(above_s), .done(hold_done)
  );

  assign rst_act = !(vmin_ok && above_s && hold_done);

  supply_rst_drive #(.ACTIVE_LOW(ACTIVE_LOW)) u_drv (
    .asserted(rst_act), .pin(rst_out)
  );

  // R2: a low synced flag means reset is active
  a_r2_low_asserts: assert property (@(posedge clk) disable iff (!vmin_ok)
    !above_s |-> rst_act);
  // R3: release only comes from a completed hold count
  a_r3_release_on_count: assert property (@(posedge clk) disable iff (!vmin_ok)
    $fell(rst_act) |-> hold_done);
  // R6: minimum-valid low forces assertion
  always_comb begin
    if (!vmin_ok) a_r6_min_forces: assert (rst_act);
  end
endmodule

// File: tb/sim_supply_rst_timer.sv
module sim_supply_rst_timer;
  localparam longint unsigned HOLD = 64'd20;

  logic clk = 1'b0;
  logic vmin_ok = 1'b0;
  logic vtrip_ok = 1'b0;
  logic rst_lo, rst_hi;
  int checks = 0;
  int errors = 0;
  int run = 0;
  bit exp_q[$];
  string tag_q[$];
  bit done_flag = 1'b0;

  always #4 clk = ~clk;

  supply_rst_timer #(.HOLD_CYCLES(HOLD), .ACTIVE_LOW(1'b1)) u0 (
    .clk(clk), .vmin_ok(vmin_ok), .vtrip_ok(vtrip_ok), .rst_out(rst_lo));
  supply_rst_timer #(.HOLD_CYCLES(HOLD), .ACTIVE_LOW(1'b0)) u1 (
    .clk(clk), .vmin_ok(vmin_ok), .vtrip_ok(vtrip_ok), .rst_out(rst_hi));

  // Driver: applies inputs for the next edge and queues the expected state
  task automatic drive(input bit vmin, input bit vtrip, input int cycles, input string tag);
    for (int i = 0; i < cycles; i++) begin
      @(negedge clk);
      vmin_ok  = vmin;
      vtrip_ok = vtrip;
      exp_q.push_back(!(vmin && run >= int'(HOLD) + 1));
      tag_q.push_back(tag);
      if (vmin && vtrip) run = (run > 1000) ? run : run + 1;
      else run = 0;
    end
  endtask

  // Monitor: samples after each rising edge and compares
  always @(posedge clk) begin
    #2;
    if (exp_q.size() > 0) begin
      bit act;
      string t;
      act = exp_q.pop_front();
      t = tag_q.pop_front();
      checks++;
      if (rst_lo !== ~act) begin
        errors++;
        $display("FAIL %s R7 active-low out=%b expected=%b t=%0t", t, rst_lo, ~act, $time);
      end
      checks++;
      if (rst_hi !== act) begin
        errors++;
        $display("FAIL %s R7 active-high out=%b expected=%b t=%0t", t, rst_hi, act, $time);
      end
    end
  end

  initial begin
    #1;
    checks++;
    if (rst_lo !== 1'b0 || rst_hi !== 1'b1) begin
      errors++;
      $display("FAIL R1 reset state lo=%b hi=%b expected lo=0 hi=1", rst_lo, rst_hi);
    end
    drive(1'b0, 1'b1, 4, "R1");
    drive(1'b1, 1'b0, 5, "R2");
    drive(1'b1, 1'b1, 30, "R3");
    drive(1'b1, 1'b1, 40, "R5");
    drive(1'b1, 1'b0, 1, "R2_R8");
    drive(1'b1, 1'b1, 12, "R4");
    drive(1'b1, 1'b0, 1, "R4");
    drive(1'b1, 1'b1, 19, "R4");
    drive(1'b1, 1'b1, 10, "R4");
    drive(1'b1, 1'b0, 3, "R2");
    drive(1'b1, 1'b1, 30, "R3");
    drive(1'b0, 1'b1, 2, "R6");
    drive(1'b1, 1'b1, 30, "R6");
    drive(1'b1, 1'b0, 4, "R2");
    @(negedge clk);
    // mid-cycle drop of the minimum-valid flag must act before any edge
    vmin_ok = 1'b0;
    #1;
    checks++;
    if (rst_lo !== 1'b0 || rst_hi !== 1'b1) begin
      errors++;
      $display("FAIL R6 async lo=%b hi=%b expected lo=0 hi=1", rst_lo, rst_hi);
    end
    repeat (3) @(posedge clk);
    #3;
    done_flag = 1'b1;
  end

  initial begin
    fork
      wait (done_flag);
      begin
        repeat (5000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired actual=running expected=done");
      end
    join_any
    disable fork;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule